// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block moves bytes in both directions over a three-wire link made of a serial clock, a data output and a data input. Each frame carries eight bits, least significant bit first. As master, the block makes the serial clock by dividing the system clock through a prescaler and a reload counter. As slave, it follows an externally supplied serial clock. The external clock is resynchronised and edge-detected inside, so the system clock must run at more than twice the external rate.

Software writes bytes into a transmit buffer. Each byte moves into the shift register as soon as that register is free, and a pending byte follows the previous one with no gap. Received bytes land in a receive buffer, which is read through a strobe. Status outputs report free space, an idle shifter, a byte waiting, and a lost byte. Two sticky interrupt request outputs, one for transmit and one for receive, stay set until their clear inputs are pulsed.

The clock-polarity select swaps the active edges and the idle level of the serial clock. In slave mode a byte is shifted only after three things: transmit is enabled, receive is enabled, and a byte (a dummy byte if nothing needs sending) has been written. Clearing the transmit enable in master mode lets the frame in progress finish and then halts the serial clock.

Top module: `csio_xcvr`

## Requirements
- R1: After reset, buf_empty and sreg_empty are 1; rx_full, overrun, tx_irq and rx_irq are 0; sd_out is 1; and sclk_out is 1 when clk_pol is 0.
- R2: In master mode each half period of the serial clock lasts (brg_div+1)·P system cycles. P is 1, 8 or 32 for pre_sel values 0, 1 and 2, and 32 for value 3.
- R3: Bits go out least significant first. Let the normalised clock be sclk_out XOR clk_pol (idle 1). sd_out changes only when the normalised clock falls, and sd_in is sampled when it rises. With clk_pol set to 1 the idle level of sclk_out is 0.
- R4: A tx_wr write makes buf_empty 0 on the next cycle, even while a frame is shifting. A pending byte starts on the falling edge that ends the previous frame's last high half, so eight clock periods span exactly 16·(brg_div+1)·P cycles across a byte boundary.
- R5: sreg_empty is 0 from the cycle a byte is loaded into the shifter until the frame ends with no further byte loaded.
- R6: With txirq_sel at 0, tx_irq is set when a byte moves from the buffer to the shifter. With txirq_sel at 1, it is set when sreg_empty becomes 1. Once set, it holds until tx_irq_clr is pulsed.
- R7: Master mode: when tx_en is 0 at the end of a frame, no further byte is loaded and sclk_out stays at its idle level. A pending byte stays buffered until tx_en returns to 1.
- R8: Slave mode (ext_clk_sel is 1): sclk_oe is 0. A frame starts only when tx_en and rx_en are 1, the buffer holds a byte, and the resynchronised external clock is at its idle level. External clock edges outside a frame change nothing.
- R9: After eight received bits with rx_en at 1, the byte appears on rx_rdata, and rx_full and rx_irq become 1. rx_irq holds until rx_irq_clr is pulsed. rx_rd clears rx_full.
- R10: overrun becomes 1 when a byte completes while rx_full is 1 and no read occurs in that cycle; rx_rdata then shows the newer byte. rx_rd clears overrun.
- R11: With rx_en at 0, a completed frame leaves rx_full and rx_rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_clk_sel | input | 1 | 1: slave, follow sclk_in; 0: master |
| clk_pol | input | 1 | Serial clock polarity select |
| pre_sel | input | 2 | Prescaler select: 0 → /1, 1 → /8, 2 or 3 → /32 |
| brg_div | input | BW | Reload value of the half-period counter |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| txirq_sel | input | 1 | Transmit request source: 0 buffer empty, 1 shifter empty |
| tx_wr | input | 1 | Transmit buffer write strobe |
| tx_wdata | input | DW | Byte to transmit |
| rx_rd | input | 1 | Receive buffer read strobe |
| rx_rdata | output | DW | Receive buffer contents |
| buf_empty | output | 1 | Transmit buffer can accept a byte |
| sreg_empty | output | 1 | Transmit shifter idle |
| rx_full | output | 1 | Unread byte in receive buffer |
| overrun | output | 1 | A byte arrived over an unread one |
| tx_irq | output | 1 | Sticky transmit interrupt request |
| tx_irq_clr | input | 1 | Clears tx_irq |
| rx_irq | output | 1 | Sticky receive interrupt request |
| rx_irq_clr | input | 1 | Clears rx_irq |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Generated serial clock |
| sclk_oe | output | 1 | Serial clock drive enable (master) |
| sd_in | input | 1 | Serial data in |
| sd_out | output | 1 | Serial data out |

## Verification
Some rules hold cycle by cycle, and the assertions check them all the time: sd_out moves only on a falling normalised clock in master mode, an idle master holds the clock at its idle level, both interrupt requests are sticky, a write always fills the buffer, and overrun rises only over an unread byte. Other behaviour depends on whole frames and can only be shown by the bench scenarios. This covers the half-period length for each prescaler, bit order in both polarities, the gapless hand-over between bytes, the halt after tx_en drops, and the slave start conditions. A loopback scoreboard compares every received byte with the byte that was sent.

// File: rtl/csio_xcvr.sv
module csio_xcvr #(
  parameter int DW = 8,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_clk_sel,
  input  logic          clk_pol,
  input  logic [1:0]    pre_sel,
  input  logic [BW-1:0] brg_div,
  input  logic          tx_en,
  input  logic          rx_en,
  input  logic          txirq_sel,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_wdata,
  input  logic          rx_rd,
  output logic [DW-1:0] rx_rdata,
  output logic          buf_empty,
  output logic          sreg_empty,
  output logic          rx_full,
  output logic          overrun,
  output logic          tx_irq,
  input  logic          tx_irq_clr,
  output logic          rx_irq,
  input  logic          rx_irq_clr,
  input  logic          sclk_in,
  output logic          sclk_out,
  output logic          sclk_oe,
  input  logic          sd_in,
  output logic          sd_out
);
  localparam int IW = $clog2(DW);
  localparam int CW = IW + 1;
  localparam int PW = 5;
  localparam logic [CW-1:0] FULL_CNT = CW'(DW);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  logic [DW-1:0] tbuf, tsh, rsh, rbuf;
  logic          tbuf_full, active, phase;
  logic [CW-1:0] bcnt;
  logic [PW-1:0] pcnt, plim;
  logic [BW-1:0] dcnt;
  logic [1:0]    sync;
  logic          sprev;

  always_comb begin
    case (pre_sel)
      2'd0:    plim = PW'(0);
      2'd1:    plim = PW'(7);
      default: plim = PW'(31);
    endcase
  end

  wire snorm  = sync[1] ^ clk_pol;
  wire s_rise = snorm & ~sprev;
  wire s_fall = ~snorm & sprev;

  wire tick    = (pcnt == plim);
  wire half    = active & ~ext_clk_sel & tick & (dcnt == '0);
  wire m_rise  = half & ~phase;
  wire m_fall  = half & phase;
  wire rise    = ext_clk_sel ? (active & s_rise) : m_rise;
  wire sl_fall = ext_clk_sel & active & s_fall & (bcnt != '0) & (bcnt != FULL_CNT);

  wire can_start = ~active & tbuf_full & tx_en & (~ext_clk_sel | (rx_en & snorm));
  wire m_chain   = m_fall & (bcnt == FULL_CNT) & tbuf_full & tx_en;
  wire load      = can_start | m_chain;

  wire [DW-1:0] rsh_nx = {sd_in, rsh[DW-1:1]};
  wire rx_done   = rise & (bcnt == LAST_BIT);
  wire frame_end = ext_clk_sel ? rx_done : (m_fall & (bcnt == FULL_CNT) & ~m_chain);
  wire tx_set    = txirq_sel ? frame_end : load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync  <= 2'b11;
      sprev <= 1'b1;
    end else begin
      sync  <= {sync[0], sclk_in};
      sprev <= snorm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbuf      <= '0;
      tbuf_full <= 1'b0;
    end else begin
      if (tx_wr) tbuf <= tx_wdata;
      tbuf_full <= (tbuf_full & ~load) | tx_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsh    <= '0;
      rsh    <= '0;
      active <= 1'b0;
      phase  <= 1'b1;
      bcnt   <= '0;
      pcnt   <= '0;
      dcnt   <= '0;
      sd_out <= 1'b1;
    end else begin
      if (active && !ext_clk_sel) begin
        pcnt <= tick ? '0 : pcnt + 1'b1;
        if (tick) dcnt <= (dcnt == '0) ? brg_div : dcnt - 1'b1;
      end
      if (m_rise) phase <= 1'b1;
      if (rise) begin
        rsh  <= rsh_nx;
        bcnt <= bcnt + 1'b1;
      end
      if (m_fall && bcnt != FULL_CNT) begin
        phase  <= 1'b0;
        sd_out <= tsh[bcnt[IW-1:0]];
      end
      if (sl_fall) sd_out <= tsh[bcnt[IW-1:0]];
      if (frame_end) begin
        active <= 1'b0;
        phase  <= 1'b1;
      end
      if (load) begin
        tsh    <= tbuf;
        sd_out <= tbuf[0];
        active <= 1'b1;
        phase  <= 1'b0;
        bcnt   <= '0;
        pcnt   <= '0;
        dcnt   <= brg_div;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf    <= '0;
      rx_full <= 1'b0;
      overrun <= 1'b0;
      rx_irq  <= 1'b0;
      tx_irq  <= 1'b0;
    end else begin
      if (rx_done && rx_en) begin
        rbuf    <= rsh_nx;
        rx_full <= 1'b1;
        overrun <= overrun | (rx_full & ~rx_rd);
      end else if (rx_rd) begin
        rx_full <= 1'b0;
        overrun <= 1'b0;
      end
      if (rx_done && rx_en) rx_irq <= 1'b1;
      else if (rx_irq_clr)  rx_irq <= 1'b0;
      if (tx_set)          tx_irq <= 1'b1;
      else if (tx_irq_clr) tx_irq <= 1'b0;
    end
  end

  assign rx_rdata   = rbuf;
  assign buf_empty  = ~tbuf_full;
  assign sreg_empty = ~active;
  assign sclk_oe    = ~ext_clk_sel;
  assign sclk_out   = (ext_clk_sel | ~active | phase) ^ clk_pol;
endmodule

// File: rtl/csio_xcvr_chk.sv
module csio_xcvr_chk (
  input logic clk,
  input logic rst_n,
  input logic ext_clk_sel,
  input logic clk_pol,
  input logic tx_wr,
  input logic rx_rd,
  input logic buf_empty,
  input logic sreg_empty,
  input logic rx_full,
  input logic overrun,
  input logic tx_irq,
  input logic tx_irq_clr,
  input logic rx_irq,
  input logic rx_irq_clr,
  input logic sclk_out,
  input logic sclk_oe,
  input logic sd_out
);
  p_sd_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_clk_sel && !$past(ext_clk_sel) && $stable(clk_pol) && (sd_out != $past(sd_out)))
      |-> ((sclk_out ^ clk_pol) == 1'b0) && (($past(sclk_out) ^ clk_pol) == 1'b1));

  p_wr_fills_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> !buf_empty);

  p_txirq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && !tx_irq_clr) |=> tx_irq);

  p_idle_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_clk_sel && sreg_empty) |-> (sclk_out == !clk_pol));

  p_slave_no_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_clk_sel |-> !sclk_oe);

  p_rxirq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && !rx_irq_clr) |=> rx_irq);

  p_full_raises_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> rx_irq);

  p_overrun_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> (rx_full && $past(rx_full) && !$past(rx_rd)));
endmodule

bind csio_xcvr csio_xcvr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ext_clk_sel(ext_clk_sel), .clk_pol(clk_pol),
  .tx_wr(tx_wr), .rx_rd(rx_rd), .buf_empty(buf_empty), .sreg_empty(sreg_empty),
  .rx_full(rx_full), .overrun(overrun), .tx_irq(tx_irq), .tx_irq_clr(tx_irq_clr),
  .rx_irq(rx_irq), .rx_irq_clr(rx_irq_clr), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
  .sd_out(sd_out)
);

// File: tb/sim_csio_xcvr.sv
module sim_csio_xcvr;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_clk_sel = 1'b0, clk_pol = 1'b0, tx_en = 1'b0, rx_en = 1'b0, txirq_sel = 1'b0;
  logic [1:0] pre_sel = 2'd0;
  logic [7:0] brg_div = 8'd0, tx_wdata = 8'd0, rx_rdata;
  logic tx_wr = 1'b0, rx_rd = 1'b0, tx_irq_clr = 1'b0, rx_irq_clr = 1'b0;
  logic buf_empty, sreg_empty, rx_full, overrun, tx_irq, rx_irq;
  logic sclk_in = 1'b1, sclk_out, sclk_oe, sd_in, sd_out;
  logic lb = 1'b1, s_sd = 1'b1;

  assign sd_in = lb ? sd_out : s_sd;
  wire norm = sclk_out ^ clk_pol;

  csio_xcvr u0 (
    .clk(clk), .rst_n(rst_n), .ext_clk_sel(ext_clk_sel), .clk_pol(clk_pol),
    .pre_sel(pre_sel), .brg_div(brg_div), .tx_en(tx_en), .rx_en(rx_en),
    .txirq_sel(txirq_sel), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd),
    .rx_rdata(rx_rdata), .buf_empty(buf_empty), .sreg_empty(sreg_empty),
    .rx_full(rx_full), .overrun(overrun), .tx_irq(tx_irq), .tx_irq_clr(tx_irq_clr),
    .rx_irq(rx_irq), .rx_irq_clr(rx_irq_clr), .sclk_in(sclk_in), .sclk_out(sclk_out),
    .sclk_oe(sclk_oe), .sd_in(sd_in), .sd_out(sd_out)
  );

  always #(CLK_P/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  bit mon_en = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic send(input logic [7:0] b, input bit push);
    while (!buf_empty) @(negedge clk);
    tx_wdata = b;
    tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    if (push) exp_q.push_back(b);
  endtask

  task automatic wait_fall();
    logic p;
    p = norm;
    @(negedge clk);
    while (!(p === 1'b1 && norm === 1'b0)) begin
      p = norm;
      @(negedge clk);
    end
  endtask

  task automatic wait_rise();
    logic p;
    p = norm;
    @(negedge clk);
    while (!(p === 1'b0 && norm === 1'b1)) begin
      p = norm;
      @(negedge clk);
    end
  endtask

  task automatic meas_low(output int n);
    n = 0;
    wait_fall();
    do begin
      n++;
      @(negedge clk);
    end while (norm === 1'b0);
  endtask

  task automatic cap_frame(output logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      wait_rise();
      v[i] = sd_out;
    end
  endtask

  task automatic wait_idle();
    while (!(sreg_empty && buf_empty && exp_q.size() == 0 && !rx_full)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic ext_frame(input logic [7:0] din, output logic [7:0] dout);
    for (int i = 0; i < 8; i++) begin
      sclk_in = 1'b0;
      s_sd = din[i];
      repeat (6) @(negedge clk);
      dout[i] = sd_out;
      sclk_in = 1'b1;
      repeat (6) @(negedge clk);
    end
  endtask

  // Scoreboard monitor: pops the expected byte on each received one (R9)
  initial begin
    forever begin
      @(negedge clk);
      if (rx_rd) rx_rd = 1'b0;
      else if (mon_en && rx_full) begin
        if (exp_q.size() == 0) chk(1'b0, "R9 unexpected byte", int'(rx_rdata), 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rx_rdata == e, "R9 received byte", int'(rx_rdata), int'(e));
        end
        rx_rd = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    report();
  end

  initial begin
    int n, t0;
    logic [7:0] v, got;
    repeat (3) @(negedge clk);
    chk(buf_empty && sreg_empty, "R1 empty flags in reset", {buf_empty, sreg_empty}, 3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(buf_empty && sreg_empty, "R1 empty flags", {buf_empty, sreg_empty}, 3);
    chk(!rx_full && !overrun && !tx_irq && !rx_irq, "R1 status clear",
        {rx_full, overrun, tx_irq, rx_irq}, 0);
    chk(sclk_out && sd_out, "R1 line levels", {sclk_out, sd_out}, 3);

    tx_en = 1'b1; rx_en = 1'b1; mon_en = 1'b1; brg_div = 8'd2; pre_sel = 2'd0;
    send(8'hA5, 1'b1);
    cap_frame(v);
    chk(v == 8'hA5, "R3 lsb-first order", int'(v), 'hA5);
    wait_idle();
    send(8'h3C, 1'b1);
    meas_low(n);
    chk(n == 3, "R2 half period /1 n=2", n, 3);
    wait_idle();
    pre_sel = 2'd1; brg_div = 8'd1;
    send(8'h5A, 1'b1);
    meas_low(n);
    chk(n == 16, "R2 half period /8 n=1", n, 16);
    wait_idle();
    pre_sel = 2'd2; brg_div = 8'd0;
    send(8'h81, 1'b1);
    meas_low(n);
    chk(n == 32, "R2 half period /32 n=0", n, 32);
    wait_idle();

    pre_sel = 2'd0; brg_div = 8'd1;
    send(8'h11, 1'b1);
    send(8'h22, 1'b1);
    chk(!buf_empty, "R4 buffer holds pending byte", buf_empty, 0);
    chk(!sreg_empty, "R5 shifter busy", sreg_empty, 0);
    wait_fall();
    t0 = cyc;
    for (int i = 0; i < 8; i++) wait_fall();
    chk(cyc - t0 == 32, "R4 no gap between frames", cyc - t0, 32);
    wait_idle();
    chk(sreg_empty, "R5 shifter empty after frames", sreg_empty, 1);

    txirq_sel = 1'b0;
    tx_irq_clr = 1'b1; @(negedge clk); tx_irq_clr = 1'b0;
    chk(!tx_irq, "R6 tx request cleared", tx_irq, 0);
    send(8'h42, 1'b1);
    @(negedge clk);
    chk(tx_irq && !sreg_empty, "R6 request on buffer transfer", {tx_irq, sreg_empty}, 2);
    wait_idle();
    chk(tx_irq, "R6 request sticky", tx_irq, 1);
    txirq_sel = 1'b1;
    tx_irq_clr = 1'b1; @(negedge clk); tx_irq_clr = 1'b0;
    send(8'h99, 1'b1);
    @(negedge clk);
    chk(!tx_irq, "R6 no request while shifting (sel 1)", tx_irq, 0);
    while (!sreg_empty) @(negedge clk);
    chk(tx_irq, "R6 request on shifter empty", tx_irq, 1);
    wait_idle();

    send(8'h0F, 1'b1);
    send(8'hF0, 1'b0);
    tx_en = 1'b0;
    while (!sreg_empty) @(negedge clk);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      logic p;
      p = norm;
      @(negedge clk);
      if (p && !norm) n++;
    end
    chk(n == 0, "R7 clock halted with tx disabled", n, 0);
    chk(!buf_empty && sclk_out, "R7 byte kept, clock idle", {buf_empty, sclk_out}, 1);
    exp_q.push_back(8'hF0);
    tx_en = 1'b1;
    wait_idle();

    mon_en = 1'b0;
    send(8'h12, 1'b0);
    send(8'h34, 1'b0);
    while (!(sreg_empty && buf_empty)) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(rx_full && overrun, "R10 overrun raised", {rx_full, overrun}, 3);
    chk(rx_rdata == 8'h34, "R10 newest byte kept", int'(rx_rdata), 'h34);
    rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
    chk(!rx_full && !overrun, "R10 read clears flags", {rx_full, overrun}, 0);
    rx_irq_clr = 1'b1; @(negedge clk); rx_irq_clr = 1'b0;
    chk(!rx_irq, "R9 rx request cleared", rx_irq, 0);

    rx_en = 1'b0;
    send(8'h77, 1'b0);
    while (!(sreg_empty && buf_empty)) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!rx_full && !rx_irq, "R11 no capture with rx disabled", {rx_full, rx_irq}, 0);
    chk(rx_rdata == 8'h34, "R11 buffer unchanged", int'(rx_rdata), 'h34);
    rx_en = 1'b1; mon_en = 1'b1;

    clk_pol = 1'b1;
    @(negedge clk);
    chk(sclk_out == 1'b0, "R3 idle level low with polarity 1", sclk_out, 0);
    send(8'hC3, 1'b1);
    cap_frame(v);
    chk(v == 8'hC3, "R3 order with polarity 1", int'(v), 'hC3);
    wait_idle();
    clk_pol = 1'b0;

    lb = 1'b0; ext_clk_sel = 1'b1;
    @(negedge clk);
    chk(!sclk_oe, "R8 clock not driven in slave", sclk_oe, 0);
    ext_frame(8'hFF, got);
    chk(!rx_full && sreg_empty, "R8 no frame without buffered byte", {rx_full, sreg_empty}, 1);
    tx_en = 1'b0;
    send(8'hE7, 1'b0);
    repeat (5) @(negedge clk);
    chk(!buf_empty, "R8 no start with tx disabled", buf_empty, 0);
    tx_en = 1'b1;
    repeat (3) @(negedge clk);
    chk(buf_empty && !sreg_empty, "R8 armed after tx enable", {buf_empty, sreg_empty}, 2);
    exp_q.push_back(8'h96);
    ext_frame(8'h96, got);
    chk(got == 8'hE7, "R8 slave transmit byte", int'(got), 'hE7);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all bytes received", exp_q.size(), 0);
    chk(sreg_empty, "R5 slave shifter idle", sreg_empty, 1);
    report();
  end
endmodule